// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block tells the command arbiter of a DDR2-style memory controller when an auto-refresh is due. It also takes the memory into and out of self-refresh. An interval counter is loaded with the number of clock cycles in one 7.8 us distributed-refresh period. Each time it expires, the block raises a refresh request and holds it until the arbiter acknowledges that the refresh command went out. Issuing one refresh per period covers every row inside the 64 ms retention window.

Self-refresh is driven by a level request. When the request is raised, the scheduler first makes sure one refresh completes. If a refresh is already outstanding, that one is reused. The scheduler then waits for the bank tracker to report that all banks are idle, drops the clock-enable output and pulses an entry strobe. The interval timer keeps running while the scheduler waits for idle banks. If the timer expires first, another refresh must complete before entry. This keeps the last refresh within one interval of entry. The memory stays in self-refresh for as long as the request is held. When the request is released, clock enable returns high, a refresh request is raised at once and the interval timer restarts.

Top module: `ref_sched_top`

## Requirements
- R1: After reset, `ref_req_o` is 0, `cke_o` is 1 and `sr_entry_o` is 0.
- R2: In normal operation, `ref_req_o` rises exactly `INTERVAL_CYC` clock cycles after the cycle in which a refresh was acknowledged, and `INTERVAL_CYC` cycles after reset release. The gap does not depend on how long the arbiter took to acknowledge.
- R3: Once raised, `ref_req_o` stays high until `ref_ack_i` is sampled high, and it is low in the following cycle.
- R4: `ref_ack_i` sampled while `ref_req_o` is low has no effect on the outputs or on when the next request rises.
- R5: A self-refresh request raises a pre-entry refresh request in the next cycle, or reuses one already outstanding. `cke_o` stays high until exactly one acknowledge has been taken.
- R6: `cke_o` falls, together with a one-cycle high pulse on `sr_entry_o`, only in the cycle after `banks_idle_i` was sampled high with no refresh outstanding. With banks already idle, this happens one cycle after the pre-entry acknowledge. While `banks_idle_i` is low, `cke_o` stays high.
- R7: While entry waits for idle banks, the interval timer keeps running. If it expires, a new refresh request rises `INTERVAL_CYC` cycles after the pre-entry acknowledge, and entry is held off until that refresh is acknowledged.
- R8: During self-refresh, `cke_o` stays low for as long as `sr_req_i` is high, `ref_req_o` stays low, and `ref_ack_i` is ignored.
- R9: When `sr_req_i` is sampled low in self-refresh, `cke_o` and `ref_req_o` both go high in the next cycle. The following request then rises `INTERVAL_CYC` cycles after that refresh is acknowledged.
- R10: If `sr_req_i` is withdrawn before entry, the block returns to normal operation. `cke_o` never falls, and an outstanding refresh request is kept until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req_o | output | 1 | Auto-refresh wanted; level until acknowledged |
| ref_ack_i | input | 1 | Arbiter issued the requested refresh (sampled while request high) |
| sr_req_i | input | 1 | Level request to be in self-refresh |
| banks_idle_i | input | 1 | All banks are precharged and idle |
| cke_o | output | 1 | Clock-enable to the memory; low while in self-refresh |
| sr_entry_o | output | 1 | One-cycle strobe: issue the self-refresh command now |

## Verification
On every cycle, the assertions check the following: the request is held until it is acknowledged and dropped right after it, clock enable falls only after idle banks with no refresh outstanding, the entry strobe coincides with that fall, no refresh is requested while clock enable is low, and a request accompanies every exit. Other behaviours can only be shown by the bench's scenarios. These are the exact interval length after each acknowledge, independence from acknowledge latency, ignored stray acknowledges, reuse of an outstanding refresh at entry, a timer expiry while waiting for idle banks, and withdrawal of the request before entry.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

    typedef enum logic [1:0] {
        SR_RUN  = 2'd0,  // normal distributed refresh
        SR_PRE  = 2'd1,  // waiting for the pre-entry refresh acknowledge
        SR_WAIT = 2'd2,  // refresh done, waiting for idle banks
        SR_SELF = 2'd3   // clock enable held low
    } sr_state_e;

    typedef struct packed {
        sr_state_e st;
        logic      cke;
        logic      entry;
    } sr_regs_t;

    typedef struct packed {
        logic req;
    } pend_regs_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    input  logic freeze_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_q, tmr_d;

    assign tick_o = (tmr_q.cnt == '0) && !freeze_i;

    always_comb begin
        tmr_d = tmr_q;
        if (reload_i) begin
            tmr_d.cnt = LAST;
        end else if (freeze_i) begin
            tmr_d.cnt = tmr_q.cnt;
        end else if (tmr_q.cnt == '0) begin
            tmr_d.cnt = LAST;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt <= LAST;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST); // R2

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (tmr_q.cnt == LAST)); // R2

endmodule

// File: rtl/ref_pending_flag.sv
module ref_pending_flag
    import ref_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);
    pend_regs_t pnd_q, pnd_d;

    assign req_o = pnd_q.req;

    always_comb begin
        pnd_d = pnd_q;
        if (clr_i) begin
            pnd_d.req = 1'b0;
        end else if (set_i) begin
            pnd_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_q.req <= 1'b0;
        end else begin
            pnd_q <= pnd_d;
        end
    end

endmodule

// File: rtl/ref_sr_fsm.sv
module ref_sr_fsm
    import ref_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req_i,
    input  logic banks_idle_i,
    input  logic tick_i,
    input  logic pend_i,
    input  logic ack_taken_i,
    output logic pend_set_o,
    output logic reload_o,
    output logic freeze_o,
    output logic cke_o,
    output logic entry_o
);
    sr_regs_t fsm_q, fsm_d;

    assign cke_o    = fsm_q.cke;
    assign entry_o  = fsm_q.entry;
    assign freeze_o = (fsm_q.st == SR_SELF);

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.entry = 1'b0;
        pend_set_o  = 1'b0;
        reload_o    = 1'b0;
        unique case (fsm_q.st)
            SR_RUN: begin
                if (sr_req_i) begin
                    if (ack_taken_i) begin
                        fsm_d.st = SR_WAIT;
                    end else begin
                        fsm_d.st   = SR_PRE;
                        pend_set_o = 1'b1;
                    end
                end
            end
            SR_PRE: begin
                if (!sr_req_i) begin
                    fsm_d.st = SR_RUN;
                end else if (ack_taken_i) begin
                    fsm_d.st = SR_WAIT;
                end
            end
            SR_WAIT: begin
                if (!sr_req_i) begin
                    fsm_d.st = SR_RUN;
                end else if (tick_i) begin
                    fsm_d.st = SR_PRE;
                end else if (banks_idle_i && !pend_i) begin
                    fsm_d.st    = SR_SELF;
                    fsm_d.cke   = 1'b0;
                    fsm_d.entry = 1'b1;
                end
            end
            SR_SELF: begin
                if (!sr_req_i) begin
                    fsm_d.st   = SR_RUN;
                    fsm_d.cke  = 1'b1;
                    pend_set_o = 1'b1;
                    reload_o   = 1'b1;
                end
            end
            default: fsm_d.st = SR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st    <= SR_RUN;
            fsm_q.cke   <= 1'b1;
            fsm_q.entry <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    AST_ENTRY_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> ($past(banks_idle_i) && !$past(pend_i))); // R6

    AST_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> $fell(cke_o)); // R6

    AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> !entry_o); // R6

    AST_HOLD_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && sr_req_i) |=> !cke_o); // R8

endmodule

// File: rtl/ref_sched_top.sv
module ref_sched_top #(
    parameter int unsigned INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_req_o,
    input  logic ref_ack_i,
    input  logic sr_req_i,
    input  logic banks_idle_i,
    output logic cke_o,
    output logic sr_entry_o
);
    logic pend;
    logic ack_taken;
    logic tick;
    logic fsm_set;
    logic fsm_reload;
    logic freeze;

    assign ack_taken = ref_ack_i && pend;
    assign ref_req_o = pend;

    ref_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload_i(ack_taken || fsm_reload),
        .freeze_i(freeze),
        .tick_o  (tick)
    );

    ref_pending_flag u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(tick || fsm_set),
        .clr_i(ack_taken),
        .req_o(pend)
    );

    ref_sr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_req_i    (sr_req_i),
        .banks_idle_i(banks_idle_i),
        .tick_i      (tick),
        .pend_i      (pend),
        .ack_taken_i (ack_taken),
        .pend_set_o  (fsm_set),
        .reload_o    (fsm_reload),
        .freeze_o    (freeze),
        .cke_o       (cke_o),
        .entry_o     (sr_entry_o)
    );

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_ack_i) |=> ref_req_o); // R3

    AST_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && ref_ack_i) |=> !ref_req_o); // R3

    AST_NO_REQ_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> !ref_req_o); // R8

    AST_EXIT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> ref_req_o); // R9

endmodule

// File: tb/ref_sched_top_tb.sv
module ref_sched_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_ack = 1'b0;
    logic sr_req = 1'b0;
    logic banks_idle = 1'b0;
    logic ref_req, cke, sr_entry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ref_sched_top #(.INTERVAL_CYC(IV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_req_o   (ref_req),
        .ref_ack_i   (ref_ack),
        .sr_req_i    (sr_req),
        .banks_idle_i(banks_idle),
        .cke_o       (cke),
        .sr_entry_o  (sr_entry)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ref_ack = 1'b1;
        step();
        ref_ack = 1'b0;
    endtask

    task automatic gap_until_req(inout int n);
        while (!ref_req && n < 400) begin
            step();
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) step();
        // R1 reset values
        chk(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
        chk(cke == 1'b1, "R1 cke", int'(cke), 1);
        chk(sr_entry == 1'b0, "R1 sr_entry", int'(sr_entry), 0);
        rst_n = 1'b1;
        n = 0;
        gap_until_req(n);
        chk(n == IV, "R2 first interval after reset", n, IV);

        // R2/R3 sweep of acknowledge latency
        for (int lat = 0; lat < 8; lat++) begin
            for (int w = 0; w < lat; w++) begin
                step();
                chk(ref_req == 1'b1, "R3 request held", int'(ref_req), 1);
            end
            pulse_ack();
            chk(ref_req == 1'b0, "R3 request dropped", int'(ref_req), 0);
            n = 0;
            gap_until_req(n);
            chk(n == IV, "R2 interval after ack", n, IV);
        end

        // R4 stray acknowledge while no request
        pulse_ack();
        n = 0;
        repeat (5) begin step(); n++; end
        pulse_ack();
        n++;
        chk(ref_req == 1'b0, "R4 stray ack", int'(ref_req), 0);
        gap_until_req(n);
        chk(n == IV, "R4 interval unchanged", n, IV);
        pulse_ack();

        // R5/R6 entry with idle banks
        sr_req = 1'b1;
        banks_idle = 1'b1;
        step();
        chk(ref_req == 1'b1, "R5 pre-entry request", int'(ref_req), 1);
        chk(cke == 1'b1, "R5 cke before ack", int'(cke), 1);
        pulse_ack();
        chk(cke == 1'b1, "R6 cke at ack", int'(cke), 1);
        step();
        chk(cke == 1'b0, "R6 cke falls", int'(cke), 0);
        chk(sr_entry == 1'b1, "R6 entry strobe", int'(sr_entry), 1);
        step();
        chk(sr_entry == 1'b0, "R6 strobe one cycle", int'(sr_entry), 0);

        // R8 stay in self-refresh, stray acks ignored
        for (int i = 0; i < 3 * IV; i++) begin
            if (i % 7 == 3) pulse_ack(); else step();
            chk(cke == 1'b0 && ref_req == 1'b0, "R8 self-refresh held",
                int'({cke, ref_req}), 0);
        end

        // R9 exit
        sr_req = 1'b0;
        step();
        chk(cke == 1'b1, "R9 cke high on exit", int'(cke), 1);
        chk(ref_req == 1'b1, "R9 refresh on exit", int'(ref_req), 1);
        pulse_ack();
        n = 0;
        gap_until_req(n);
        chk(n == IV, "R9 interval after exit refresh", n, IV);
        pulse_ack();

        // R7 timer expiry while banks busy
        sr_req = 1'b1;
        banks_idle = 1'b0;
        step();
        chk(ref_req == 1'b1, "R5 pre-entry request busy banks", int'(ref_req), 1);
        pulse_ack();
        n = 0;
        while (!ref_req && n < 400) begin
            step();
            n++;
            chk(cke == 1'b1, "R6 cke high while banks busy", int'(cke), 1);
        end
        chk(n == IV, "R7 second request while waiting", n, IV);
        banks_idle = 1'b1;
        repeat (3) begin
            step();
            chk(cke == 1'b1 && ref_req == 1'b1, "R7 entry held off",
                int'({cke, ref_req}), 3);
        end
        pulse_ack();
        step();
        chk(cke == 1'b0, "R7 entry after second refresh", int'(cke), 0);
        sr_req = 1'b0;
        step();
        chk(cke == 1'b1 && ref_req == 1'b1, "R9 exit again", int'({cke, ref_req}), 3);
        pulse_ack();

        // R5 reuse an outstanding request
        n = 0;
        gap_until_req(n);
        sr_req = 1'b1;
        repeat (4) begin
            step();
            chk(cke == 1'b1 && ref_req == 1'b1, "R5 waits for outstanding",
                int'({cke, ref_req}), 3);
        end
        pulse_ack();
        step();
        chk(cke == 1'b0, "R5 single ack suffices", int'(cke), 0);
        sr_req = 1'b0;
        step();
        pulse_ack();

        // R10 withdrawal before entry
        banks_idle = 1'b0;
        sr_req = 1'b1;
        step();
        step();
        sr_req = 1'b0;
        repeat (5) begin
            step();
            chk(cke == 1'b1 && ref_req == 1'b1, "R10 back to normal, request kept",
                int'({cke, ref_req}), 3);
        end
        pulse_ack();
        chk(ref_req == 1'b0, "R10 request cleared", int'(ref_req), 0);
        n = 0;
        gap_until_req(n);
        chk(n == IV, "R10 interval after withdrawal", n, IV);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule